// File: doc/BRIEF.md
# External Exception Request and Checkstop Controller

This block sits between the pins that carry exception requests from outside the core and the core's exception sequencer. It takes three level-sensitive requests: a general interrupt, a system management interrupt and a machine check. Each can change at any moment with no relation to the clock, so each passes through a two-flop synchronizer first. The synchronized requests are qualified by three machine-state control bits: an external-enable bit, a machine-check-enable bit and a machine-check-pin-enable bit. The highest-priority qualified request is then offered to the sequencer as a request flag with a two-bit cause code. The offer is held until the sequencer answers with a one-cycle `taken` pulse. In that cycle the block tells the machine-state logic which enable bit to clear.

A machine check that arrives while the pin-enable bit is set and machine checks are disabled is not recoverable. The block enters a sticky checkstop state and stays there until reset. In checkstop, the internal clock enable drops, the global output enable drops so the pads can float, and a dedicated checkstop output rises. That output is the only one that stays driven. No further requests are offered in checkstop.

The controller has three states. **IDLE** waits for a qualified request. **PEND** offers the latched cause and waits for `taken`. **CHKSTOP** is terminal. The transitions are:
- IDLE→PEND on any qualified request, with the cause latched.
- PEND→IDLE on `taken`.
- IDLE→CHKSTOP and PEND→CHKSTOP on a disabled machine check with the pin enable set.
- CHKSTOP→IDLE only through the synchronous reset.

Top module: `exc_ctrl`

## Requirements
- R1: Each request input reaches the decision logic through two flops. A request applied before clock edge k is first seen at the outputs after edge k+2, and is not yet visible after edge k+1.
- R2: A general interrupt produces `req`=1 with `cause`=2'b01 only while `ee_bit` is 1.
- R3: A system management interrupt produces `req`=1 with `cause`=2'b10 only while `ee_bit` is 1.
- R4: A machine check with both `me_bit`=1 and `mcpen_bit`=1 produces `req`=1 with `cause`=2'b11.
- R5: A machine check with `mcpen_bit`=1 and `me_bit`=0 enters checkstop. In checkstop, `chkstop`=1, `clk_en`=0, `out_en`=0 and `req`=0. Outside checkstop, `chkstop`=0, `clk_en`=1 and `out_en`=1.
- R6: When `mcpen_bit` is 0, the machine check input has no effect at all: no request and no checkstop.
- R7: When several qualified requests are present at once, machine check wins over system management interrupt, which wins over general interrupt. When `req`=0, `cause` reads 2'b00.
- R8: Once raised, `req` and its `cause` stay constant until `taken` is seen, even if the inputs change.
- R9: In the cycle `taken` is high while `req` is high, exactly one clear pulse is emitted. It is `clr_ee` for cause 2'b01 or 2'b10, and `clr_me` for cause 2'b11. `req` is low after that edge. No clear pulse appears at any other time.
- R10: Checkstop persists whatever the inputs do, and only `rst` leaves it. While in checkstop, no request is ever raised.
- R11: A general interrupt that rises and falls while `ee_bit` is 0 is not remembered. Setting `ee_bit` afterwards raises no request.
- R12: A checkstop condition that arises while a request is pending overrides it. The pending request is withdrawn and the block enters checkstop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, the only exit from checkstop |
| irq_in | input | 1 | Asynchronous level general interrupt request |
| smi_in | input | 1 | Asynchronous level system management interrupt request |
| mchk_in | input | 1 | Asynchronous level machine check request |
| ee_bit | input | 1 | External-enable machine-state bit |
| me_bit | input | 1 | Machine-check-enable machine-state bit |
| mcpen_bit | input | 1 | Machine-check-pin-enable control bit |
| taken | input | 1 | One-cycle acknowledge from the exception sequencer |
| req | output | 1 | Exception request to the sequencer |
| cause | output | 2 | 01 interrupt, 10 system management, 11 machine check, 00 none |
| clr_ee | output | 1 | One-cycle pulse: clear the external-enable bit |
| clr_me | output | 1 | One-cycle pulse: clear the machine-check-enable bit |
| clk_en | output | 1 | Internal clock enable, low in checkstop |
| out_en | output | 1 | Global output enable, low in checkstop |
| chkstop | output | 1 | Checkstop indicator, high in checkstop |

## Verification
The hardest situation to reach from the ports is a checkstop that interrupts a request already being offered. The bench first raises a qualified general interrupt and lets it reach PEND without answering `taken`. Only then does it raise a disabled machine check with the pin enable set, and it checks that the offer is withdrawn as checkstop appears. All sixty-four combinations of the three requests and three control bits are swept from reset against an arithmetically computed expectation. The bench also checks the sync latency at both the second and the third edge, and probes checkstop stickiness by releasing the inputs and re-enabling everything.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_IRQ  = 2'b01,
        CAUSE_SMI  = 2'b10,
        CAUSE_MCHK = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_PEND    = 2'b01,
        ST_CHKSTOP = 2'b10
    } state_e;

    localparam int SRC_IRQ  = 0;
    localparam int SRC_SMI  = 1;
    localparam int SRC_MCHK = 2;
    localparam int NUM_SRC  = 3;

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = stg[LAST];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_ctrl_pkg::*;
(
    input  logic [NUM_SRC-1:0] src,
    input  logic               ee_bit,
    input  logic               me_bit,
    input  logic               mcpen_bit,
    output cause_e             win,
    output logic               chk_hit
);
    logic mc_ok, smi_ok, irq_ok;

    always_comb begin
        mc_ok   = src[SRC_MCHK] & mcpen_bit & me_bit;
        smi_ok  = src[SRC_SMI]  & ee_bit;
        irq_ok  = src[SRC_IRQ]  & ee_bit;
        chk_hit = src[SRC_MCHK] & mcpen_bit & ~me_bit;
        if (mc_ok)       win = CAUSE_MCHK;
        else if (smi_ok) win = CAUSE_SMI;
        else if (irq_ok) win = CAUSE_IRQ;
        else             win = CAUSE_NONE;
    end

    // R6: a cleared pin enable never lets the machine check through
    always_comb begin
        a_r6_pin_gate: assert (mcpen_bit || (win != CAUSE_MCHK && !chk_hit));
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_in,
    input  logic       smi_in,
    input  logic       mchk_in,
    input  logic       ee_bit,
    input  logic       me_bit,
    input  logic       mcpen_bit,
    input  logic       taken,
    output logic       req,
    output logic [1:0] cause,
    output logic       clr_ee,
    output logic       clr_me,
    output logic       clk_en,
    output logic       out_en,
    output logic       chkstop
);
    logic [NUM_SRC-1:0] raw_src;
    logic [NUM_SRC-1:0] sync_src;
    cause_e             win;
    logic               chk_hit;
    state_e             state;
    cause_e             held;

    always_comb begin
        raw_src           = '0;
        raw_src[SRC_IRQ]  = irq_in;
        raw_src[SRC_SMI]  = smi_in;
        raw_src[SRC_MCHK] = mchk_in;
    end

    exc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_src),
        .sync_out (sync_src)
    );

    exc_arbiter u_arb (
        .src       (sync_src),
        .ee_bit    (ee_bit),
        .me_bit    (me_bit),
        .mcpen_bit (mcpen_bit),
        .win       (win),
        .chk_hit   (chk_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            held  <= CAUSE_NONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (chk_hit) begin
                        state <= ST_CHKSTOP;
                    end else if (win != CAUSE_NONE) begin
                        state <= ST_PEND;
                        held  <= win;
                    end
                end
                ST_PEND: begin
                    if (chk_hit) begin
                        state <= ST_CHKSTOP;
                        held  <= CAUSE_NONE;
                    end else if (taken) begin
                        state <= ST_IDLE;
                        held  <= CAUSE_NONE;
                    end
                end
                ST_CHKSTOP: begin
                    state <= ST_CHKSTOP;
                end
                default: begin
                    state <= ST_IDLE;
                    held  <= CAUSE_NONE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        req     = 1'b0;
        cause   = CAUSE_NONE;
        clr_ee  = 1'b0;
        clr_me  = 1'b0;
        clk_en  = 1'b1;
        out_en  = 1'b1;
        chkstop = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PEND: begin
                req   = 1'b1;
                cause = held;
                if (taken) begin
                    clr_me = (held == CAUSE_MCHK);
                    clr_ee = (held != CAUSE_MCHK);
                end
            end
            ST_CHKSTOP: begin
                clk_en  = 1'b0;
                out_en  = 1'b0;
                chkstop = 1'b1;
            end
            default: ;
        endcase
    end

    // R10: checkstop is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        chkstop |=> chkstop);

    // R5: checkstop silences clock, outputs and requests
    a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
        chkstop |-> (!clk_en && !out_en && !req));

    // R8: request held with stable cause until taken
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (req && !taken) |=> ((req && $stable(cause)) || chkstop));

    // R9: at most one clear pulse, only with taken on a live request
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_ee || clr_me) |-> (taken && req && $onehot0({clr_ee, clr_me})));

    // R9: request falls after being taken
    a_r9_drop: assert property (@(posedge clk) disable iff (rst)
        (req && taken) |=> !req);

    // R7: cause is zero exactly when no request is offered
    a_r7_cause_idle: assert property (@(posedge clk) disable iff (rst)
        (req == (cause != 2'b00)));
endmodule

// File: tb/sim_exc_ctrl.sv
`timescale 1ns/1ps
module sim_exc_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_in = 0, smi_in = 0, mchk_in = 0;
    logic       ee_bit = 0, me_bit = 0, mcpen_bit = 0, taken = 0;
    logic       req, clr_ee, clr_me, clk_en, out_en, chkstop;
    logic [1:0] cause;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    exc_ctrl u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .smi_in(smi_in), .mchk_in(mchk_in),
        .ee_bit(ee_bit), .me_bit(me_bit), .mcpen_bit(mcpen_bit), .taken(taken),
        .req(req), .cause(cause), .clr_ee(clr_ee), .clr_me(clr_me),
        .clk_en(clk_en), .out_en(out_en), .chkstop(chkstop)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        irq_in = 0; smi_in = 0; mchk_in = 0; taken = 0;
        ee_bit = 0; me_bit = 0; mcpen_bit = 0;
        rst = 1;
        cyc(4);
        rst = 0;
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // reset state (R5 idle side)
        check("R5 reset req", req, 0);
        check("R5 reset cause", cause, 0);
        check("R5 reset chkstop", chkstop, 0);
        check("R5 reset clk_en", clk_en, 1);
        check("R5 reset out_en", out_en, 1);

        // sweep all request / control combinations
        for (int v = 0; v < 64; v++) begin
            automatic int ir = v & 1, sm = (v >> 1) & 1, mc = (v >> 2) & 1;
            automatic int ee = (v >> 3) & 1, me = (v >> 4) & 1, pe = (v >> 5) & 1;
            automatic int ecs = mc & pe & (1 - me);
            automatic int ecause = (mc & pe & me) ? 3 : (sm & ee) ? 2 : (ir & ee) ? 1 : 0;
            automatic int ereq = (ecs == 0 && ecause != 0) ? 1 : 0;
            do_reset();
            ee_bit = ee[0]; me_bit = me[0]; mcpen_bit = pe[0];
            irq_in = ir[0]; smi_in = sm[0]; mchk_in = mc[0];
            cyc(2);
            check("R1 latency req", req, 0);
            check("R1 latency chkstop", chkstop, 0);
            cyc(1);
            // R2 R3 R4 R6 R7
            check("R7 sweep req", req, ereq);
            check("R7 sweep cause", cause, ecause * ereq);
            check("R5 sweep chkstop", chkstop, ecs);
            check("R5 sweep clk_en", clk_en, 1 - ecs);
            check("R5 sweep out_en", out_en, 1 - ecs);
            if (ereq == 1) begin
                irq_in = 0; smi_in = 0; mchk_in = 0;
                cyc(3);
                check("R8 hold req", req, 1);
                check("R8 hold cause", cause, ecause);
                taken = 1;
                #1;
                check("R9 clr_ee", clr_ee, (ecause != 3) ? 1 : 0);
                check("R9 clr_me", clr_me, (ecause == 3) ? 1 : 0);
                cyc(1);
                taken = 0;
                #1;
                check("R9 req drop", req, 0);
                check("R9 no clr", clr_ee | clr_me, 0);
            end
            if (ecs == 1) begin
                irq_in = 1; smi_in = 0; mchk_in = 0;
                ee_bit = 1; me_bit = 1;
                cyc(6);
                check("R10 sticky", chkstop, 1);
                check("R10 no req", req, 0);
                check("R10 clk_en", clk_en, 0);
            end
        end

        // R11: pulse while disabled is not remembered
        do_reset();
        irq_in = 1;
        cyc(5);
        check("R11 disabled req", req, 0);
        irq_in = 0;
        cyc(3);
        ee_bit = 1;
        cyc(5);
        check("R11 after enable", req, 0);

        // R12: checkstop overrides a pending request
        do_reset();
        ee_bit = 1; irq_in = 1;
        cyc(3);
        check("R12 pending req", req, 1);
        check("R12 pending cause", cause, 1);
        mcpen_bit = 1; me_bit = 0; mchk_in = 1;
        cyc(2);
        check("R12 still pending", req, 1);
        cyc(1);
        check("R12 chkstop", chkstop, 1);
        check("R12 req withdrawn", req, 0);
        check("R12 out_en", out_en, 0);

        // R10: only reset leaves checkstop
        do_reset();
        check("R10 reset exits", chkstop, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule